// File: doc/BRIEF.md
# One-Cycle Current-Integrating Switching Sequencer

This block sequences the six bidirectional switches of a three-phase-to-DC matrix rectifier under one-cycle control. The switching period is a fixed number of sample ticks. At the first tick of each period the block captures a sector code and two charge references. Each reference is the magnitude of the demanded current of one auxiliary phase multiplied by the switching period. The sector code says which input phase is dominant, meaning its current has the opposite sign to the other two, and whether that phase carries positive or negative current.

Within a period the block has three intervals. In the first, the output return path connects to one auxiliary phase. Each tick, a sample of the load current is added to an integrator, until the sum reaches the first reference. The integrator is then cleared and the second auxiliary phase is connected, until the sum reaches the second reference. For the rest of the period both switches of the dominant phase leg conduct, which is the freewheel state. In that state no power is transferred and the integrator stays at zero. The interval state is mapped to six gate commands by rotating the phase roles according to the sector. If a period ends before its freewheel state is reached, it is cut short and a saturation flag is raised for the next period.

Top module: `one_cycle_seq`

## Requirements
- R1: A synchronous active-high reset gives gates = 6'b000011 (only S1 and S2 on), the freewheel state (sZero = 1, sAlpha = sBeta = 0) and satFlag = 0. The latched sector becomes 1.
- R2: Ticks are counted modulo TICKS_PER_PERIOD, and the first tick after reset is a period boundary. A boundary tick captures refA, refB and sectorIn, clears the integrator and enters the alpha interval.
- R3: In the alpha interval, each non-boundary tick adds curSample to the integrator. At the tick where the sum is greater than or equal to the captured refA, the block clears the integrator and enters the beta interval. A reference of 0 therefore ends its interval at the first such tick.
- R4: The beta interval does the same against the captured refB, then enters the freewheel interval.
- R5: The freewheel interval lasts until the next boundary tick. The integrator stays at zero in it.
- R6: Changes of refA, refB and sectorIn at any tick other than a boundary have no effect on the sequence.
- R7: At a boundary tick, satFlag is set to 1 if the period just ended had not reached freewheel, and to 0 otherwise. It keeps that value until the next boundary.
- R8: Bit i of gates drives switch S(i+1). Upper switches S1, S3 and S5 (bits 0, 2, 4) connect phases a, b and c to the positive rail. Lower switches S2, S4 and S6 (bits 1, 3, 5) connect phases a, b and c to the return rail.
- R9: The dominant phase (a=0, b=1, c=2) is 0, 2, 1, 0, 2, 1 for sectors 1 to 6. It is positive in odd sectors. The alpha phase is (dominant+2) mod 3 and the beta phase is (dominant+1) mod 3.
- R10: With a positive dominant phase, that phase's upper switch is on for the whole period and the lower switch of the active phase is on. With a negative dominant phase, the roles of the upper and lower switches are swapped.
- R11: Exactly one upper switch and exactly one lower switch are on at all times. In freewheel they form the same phase leg, and in alpha or beta they do not.
- R12: Sector codes 0 and 7 are handled as sector 1.
- R13: Without a tick, gates, the interval outputs and satFlag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle strobe for each current sample |
| curSample | input | SAMPLE_W | Load-current sample, unsigned |
| refA | input | REF_W | Charge reference for the alpha interval |
| refB | input | REF_W | Charge reference for the beta interval |
| sectorIn | input | 3 | Sector code, 1 to 6 |
| gates | output | 6 | Gate commands, bit i drives S(i+1) |
| sAlpha | output | 1 | Alpha interval active |
| sBeta | output | 1 | Beta interval active |
| sZero | output | 1 | Freewheel interval active |
| satFlag | output | 1 | The previous period ended without reaching freewheel |

## Verification
The assertions assume that reset is held from time zero until the first clock edges. They also assume that tickEn is a single-cycle pulse with idle cycles between pulses, so that every interval change lines up with a tick. The stimulus drives every input only on falling edges. It raises tickEn for one cycle and then holds it low for two cycles. Outside boundary ticks it deliberately presents different sector and reference values, so the capture rule is exercised on every period.

// File: rtl/oc_seq_pkg.sv
`timescale 1ns/1ps
package oc_seq_pkg;

  typedef enum logic [1:0] {PH_ALPHA = 2'd0, PH_BETA = 2'd1, PH_ZERO = 2'd2} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic clear;
    logic accumulate;
    logic selBeta;
  } dpCtrl_t;

  typedef struct packed {
    logic [1:0] dom;
    logic       pos;
  } roles_t;

  function automatic roles_t sectorRoles(input logic [2:0] sec);
    roles_t r;
    case (sec)
      3'd2:    begin r.dom = 2'd2; r.pos = 1'b0; end
      3'd3:    begin r.dom = 2'd1; r.pos = 1'b1; end
      3'd4:    begin r.dom = 2'd0; r.pos = 1'b0; end
      3'd5:    begin r.dom = 2'd2; r.pos = 1'b1; end
      3'd6:    begin r.dom = 2'd1; r.pos = 1'b0; end
      default: begin r.dom = 2'd0; r.pos = 1'b1; end  // sector 1, and codes 0 and 7
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ocs_datapath.sv
`timescale 1ns/1ps
module ocs_datapath
  import oc_seq_pkg::*;
#(
  parameter int TICKS_PER_PERIOD = 10,
  parameter int SAMPLE_W = 8,
  parameter int REF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  logic [SAMPLE_W-1:0] curSample,
  input  logic [REF_W-1:0]    refA,
  input  logic [REF_W-1:0]    refB,
  input  logic [2:0]          sectorIn,
  input  dpCtrl_t             ctrl,
  output logic                boundary,
  output logic                hitRef,
  output logic [2:0]          sectorLat
);
  localparam int CNT_W = (TICKS_PER_PERIOD > 1) ? $clog2(TICKS_PER_PERIOD) : 1;
  localparam int ACC_W = ((SAMPLE_W > REF_W) ? SAMPLE_W : REF_W) + 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_PERIOD - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] newSum;
  logic [REF_W-1:0] refALat;
  logic [REF_W-1:0] refBLat;
  logic [REF_W-1:0] activeRef;

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (tickEn) begin
      tickCnt <= (tickCnt == LAST_TICK) ? '0 : tickCnt + 1'b1;
    end
  end

  assign boundary  = (tickCnt == '0);
  assign newSum    = acc + ACC_W'(curSample);
  assign activeRef = ctrl.selBeta ? refBLat : refALat;
  assign hitRef    = (newSum >= ACC_W'(activeRef));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (ctrl.clear) begin
      acc <= '0;
    end else if (ctrl.accumulate) begin
      acc <= newSum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refALat   <= '0;
      refBLat   <= '0;
      sectorLat <= 3'd1;
    end else if (ctrl.latch) begin
      refALat   <= refA;
      refBLat   <= refB;
      sectorLat <= sectorIn;
    end
  end
endmodule

// File: rtl/ocs_control.sv
`timescale 1ns/1ps
module ocs_control
  import oc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tickEn,
  input  logic    boundary,
  input  logic    hitRef,
  output dpCtrl_t ctrl,
  output phase_t  phase,
  output logic    satFlag
);
  phase_t nextPhase;
  logic   nextSat;

  always_comb begin
    ctrl      = '0;
    nextPhase = phase;
    nextSat   = satFlag;
    if (tickEn) begin
      if (boundary) begin
        ctrl.latch = 1'b1;
        ctrl.clear = 1'b1;
        nextPhase  = PH_ALPHA;
        nextSat    = (phase != PH_ZERO);
      end else if (phase != PH_ZERO) begin
        ctrl.accumulate = 1'b1;
        if (hitRef) begin
          ctrl.clear = 1'b1;
          nextPhase  = (phase == PH_ALPHA) ? PH_BETA : PH_ZERO;
        end
      end
    end
    ctrl.selBeta = (phase == PH_BETA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ZERO;
      satFlag <= 1'b0;
    end else begin
      phase   <= nextPhase;
      satFlag <= nextSat;
    end
  end
endmodule

// File: rtl/ocs_gate_map.sv
`timescale 1ns/1ps
module ocs_gate_map
  import oc_seq_pkg::*;
(
  input  phase_t     phase,
  input  logic [2:0] sectorLat,
  output logic [5:0] gates
);
  roles_t     roles;
  logic [1:0] alphaPh;
  logic [1:0] betaPh;
  logic [1:0] activePh;

  assign roles    = sectorRoles(sectorLat);
  assign alphaPh  = (roles.dom == 2'd0) ? 2'd2 : roles.dom - 2'd1;
  assign betaPh   = (roles.dom == 2'd2) ? 2'd0 : roles.dom + 2'd1;
  assign activePh = (phase == PH_ALPHA) ? alphaPh :
                    (phase == PH_BETA)  ? betaPh  : roles.dom;

  for (genvar p = 0; p < 3; p++) begin : gLeg
    assign gates[2*p]   = roles.pos ? (roles.dom == 2'(p)) : (activePh == 2'(p));
    assign gates[2*p+1] = roles.pos ? (activePh == 2'(p))  : (roles.dom == 2'(p));
  end
endmodule

// File: rtl/one_cycle_seq.sv
`timescale 1ns/1ps
module one_cycle_seq
  import oc_seq_pkg::*;
#(
  parameter int TICKS_PER_PERIOD = 10,
  parameter int SAMPLE_W = 8,
  parameter int REF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  logic [SAMPLE_W-1:0] curSample,
  input  logic [REF_W-1:0]    refA,
  input  logic [REF_W-1:0]    refB,
  input  logic [2:0]          sectorIn,
  output logic [5:0]          gates,
  output logic                sAlpha,
  output logic                sBeta,
  output logic                sZero,
  output logic                satFlag
);
  dpCtrl_t    ctrl;
  phase_t     phase;
  logic       boundary;
  logic       hitRef;
  logic [2:0] sectorLat;

  ocs_datapath #(
    .TICKS_PER_PERIOD(TICKS_PER_PERIOD),
    .SAMPLE_W(SAMPLE_W),
    .REF_W(REF_W)
  ) uDp (
    .clk(clk), .rst(rst), .tickEn(tickEn), .curSample(curSample),
    .refA(refA), .refB(refB), .sectorIn(sectorIn), .ctrl(ctrl),
    .boundary(boundary), .hitRef(hitRef), .sectorLat(sectorLat)
  );

  ocs_control uCtl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .boundary(boundary),
    .hitRef(hitRef), .ctrl(ctrl), .phase(phase), .satFlag(satFlag)
  );

  ocs_gate_map uMap (.phase(phase), .sectorLat(sectorLat), .gates(gates));

  assign sAlpha = (phase == PH_ALPHA);
  assign sBeta  = (phase == PH_BETA);
  assign sZero  = (phase == PH_ZERO);
endmodule

// File: rtl/oc_seq_checker.sv
`timescale 1ns/1ps
module oc_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       tickEn,
  input logic [5:0] gates,
  input logic       sAlpha,
  input logic       sBeta,
  input logic       sZero,
  input logic       satFlag
);
  logic [2:0] upperOn;
  logic [2:0] lowerOn;
  logic       sameLeg;

  assign upperOn = {gates[4], gates[2], gates[0]};
  assign lowerOn = {gates[5], gates[3], gates[1]};
  assign sameLeg = |(upperOn & lowerOn);

  assert_one_upper_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(upperOn) == 1);
  assert_one_lower_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(lowerOn) == 1);
  assert_freewheel_leg_R11: assert property (@(posedge clk) disable iff (rst)
    sZero == sameLeg);
  assert_single_interval_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({sAlpha, sBeta, sZero}) == 1);
  assert_beta_after_alpha_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sBeta) |-> $past(sAlpha));
  assert_sat_unfinished_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(satFlag) |-> ($past(!sZero) && sAlpha));
  assert_hold_no_tick_R13: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> ($stable(gates) && $stable(satFlag) && $stable(sZero)));
endmodule

bind one_cycle_seq oc_seq_checker uChk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .gates(gates),
  .sAlpha(sAlpha), .sBeta(sBeta), .sZero(sZero), .satFlag(satFlag)
);

// File: tb/one_cycle_seq_test.sv
`timescale 1ns/1ps
module one_cycle_seq_test;
  localparam int NT = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic [7:0]  curSample = '0;
  logic [11:0] refA = '0;
  logic [11:0] refB = '0;
  logic [2:0]  sectorIn = 3'd1;
  logic [5:0]  gates;
  logic        sAlpha, sBeta, sZero, satFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state: 0 alpha, 1 beta, 2 freewheel
  int eSt = 2, eSum = 0, eSat = 0, eSec = 1, eRa = 0, eRb = 0, k = 0;

  always #2.5 clk = ~clk;

  one_cycle_seq uut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .curSample(curSample),
    .refA(refA), .refB(refB), .sectorIn(sectorIn), .gates(gates),
    .sAlpha(sAlpha), .sBeta(sBeta), .sZero(sZero), .satFlag(satFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (sector %0d tick %0d)", tag, act, exp, eSec, k);
    end
  endtask

  function automatic int expGates(input int sec, input int st);
    int s, pos, dom, act, upPh, loPh;
    s    = (sec < 1 || sec > 6) ? 1 : sec;       // R12
    pos  = s % 2;                                // R9
    dom  = (3 - ((s - 1) % 3)) % 3;
    act  = (st == 0) ? (dom + 2) % 3 : (st == 1) ? (dom + 1) % 3 : dom;
    upPh = pos ? dom : act;                      // R10
    loPh = pos ? act : dom;
    return (1 << (2 * upPh)) | (1 << (2 * loPh + 1));  // R8
  endfunction

  function automatic int expPhase(input int st);
    return (st == 0) ? 4 : (st == 1) ? 2 : 1;
  endfunction

  task automatic doTick(input int smp, input int ra, input int rb, input int sec);
    int g0;
    string tg;
    @(negedge clk);
    curSample = 8'(smp);
    refA = 12'(ra);
    refB = 12'(rb);
    sectorIn = 3'(sec);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    if (k == 0) begin
      eSat = (eSt != 2);
      eSt = 0; eSum = 0;
      eRa = ra; eRb = rb; eSec = sec;
    end else if (eSt < 2) begin
      eSum += smp;
      if (eSum >= ((eSt == 0) ? eRa : eRb)) begin
        eSt++;
        eSum = 0;
      end
    end
    if (k == 0) tg = "R2";
    else if (eSt == 0) tg = "R3/R6";
    else if (eSt == 1) tg = "R4/R6";
    else tg = "R5/R6";
    check(tg, int'({sAlpha, sBeta, sZero}), expPhase(eSt));
    if (eSec == 0 || eSec == 7) tg = "R12";
    else tg = "R8/R9/R10/R11";
    check(tg, int'(gates), expGates(eSec, eSt));
    check("R7", int'(satFlag), eSat);
    g0 = int'({gates, sAlpha, sBeta, sZero, satFlag});
    @(negedge clk);
    check("R13", int'({gates, sAlpha, sBeta, sZero, satFlag}), g0);
    k = (k + 1) % NT;
  endtask

  task automatic runPeriod(input int sec, input int ra, input int rb, input int base, input int step);
    for (int t = 0; t < NT; t++) begin
      int smp;
      smp = base + ((t % 2 == 1) ? step : 0);
      if (t == 0) doTick(smp, ra, rb, sec);
      else doTick(smp, (ra ^ 'h5a5) & 'hfff, (rb + 3) & 'hfff, sec ^ 5);  // R6 disturbance
    end
  endtask

  initial begin
    int refs[4];
    int bases[3];
    int steps[3];
    refs = '{0, 7, 30, 100};
    bases = '{0, 3, 17};
    steps = '{0, 1, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", int'(gates), 6'b000011);
    check("R1", int'({sAlpha, sBeta, sZero}), 1);
    check("R1", int'(satFlag), 0);
    for (int sec = 0; sec < 8; sec++)
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          for (int ip = 0; ip < 3; ip++)
            runPeriod(sec, refs[ia], refs[ib], bases[ip], steps[ip]);
    runPeriod(3, 5, 5, 9, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule